// File: doc/BRIEF.md
# Quadrature Encoder x4 Up/Down Counter

This block serves one axis of a two-phase incremental encoder. The two phase inputs arrive with no relation to the system clock. Each one passes through a short synchroniser. The block then compares the newly sampled two-bit phase state with the state from the previous cycle. A legal transition moves a modulo-4096 position counter one step up or one step down. Every edge on either phase counts, so one full encoder cycle gives four counts. Two instances of the block give an X and a Y axis.

Downstream flag logic watches a one-cycle event strobe, which goes high whenever the counter value changes. A transition where both phases moved within the same sample period cannot be decoded. Such a transition produces no count and pulses an error output. The count can only be initialised by a dedicated active-high clear input, which has priority over counting. The system reset is synchronous and active low, and it returns every register to zero.

Top module: `quad_axis_counter`

## Requirements
- R1: When the sampled state {phase_a, phase_b} follows the order 00, 10, 11, 01, 00 (phase A leading), each step adds one to `count`.
- R2: When the sampled state follows the order 00, 01, 11, 10, 00 (phase B leading), each step subtracts one from `count`.
- R3: A phase input is first captured at some rising clock edge. Its effect on `count` and `count_evt` appears at the second rising edge after that capture edge.
- R4: While `rst_n` is low at a rising edge, `count` is 000h and `count_evt` and `seq_err` are 0 after that edge.
- R5: `count` is 12 bits wide and wraps in both directions: FFFh plus one gives 000h, and 000h minus one gives FFFh.
- R6: A rising edge at which `cnt_clr` is high sets `count` to 000h. This includes an edge where a step would otherwise apply. Phase edges decoded while `cnt_clr` is high are lost and are never counted later. No other input clears the count.
- R7: A pulse on one phase that returns to its old level before the other phase changes leaves `count` at its value from before the pulse.
- R8: A sampled transition in which both phases change at once leaves `count` unchanged. It raises `seq_err` for exactly that one cycle.
- R9: `count_evt` is high for exactly those cycles in which `count` differs from its value in the previous cycle.
- R10: While both phase inputs stay steady, `count` holds its value and `count_evt` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_clr | input | 1 | Active-high count clear, sampled on the clock |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| count | output | 12 | Current position count |
| count_evt | output | 1 | High for one cycle after every change of `count` |
| seq_err | output | 1 | High for one cycle after a transition where both phases changed at once |

## Verification
The count clear and a decoded phase step can land on the same clock edge. When they do, the clear must win, and the lost step must never show up later. The bench provokes this by changing one phase and then raising `cnt_clr` exactly two falling edges later. The clear is then sampled on the edge where that step would apply. The bench judges the outcome by requiring `count` to read zero from that edge onward. It also requires that the next real step brings the count to one. A behavioural reference model is compared on every cycle, so any step that slips past the clear is caught at once.

// File: rtl/quad_pkg.sv
// Shared types for the quadrature axis counter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package quad_pkg;

    // Result of decoding one sampled phase transition
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;

endpackage

// File: rtl/quad_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is treated on its own; bits that change together may
// land in different cycles, which the downstream decoder tolerates.
module quad_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                // Later stages retime the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/quad_decode.sv
// Transition decoder: keeps the previous sampled {A,B} state and classifies
// the move to the current state as up, down, none or illegal (both changed).
// Assumes: cur is already synchronous to clk; up order is 00,10,11,01.
module quad_decode
    import quad_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cur,
    output step_t       step
);

    logic [1:0] prev_q;

    // Remember last cycle's sampled phase state
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= cur;
    end

    // Classify the transition prev_q -> cur
    always_comb begin
        case ({prev_q, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
            4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: step = STEP_DOWN;
            4'b00_11, 4'b11_00, 4'b10_01, 4'b01_10: step = STEP_BAD;
            default:                                step = STEP_NONE;
        endcase
    end

endmodule

// File: rtl/quad_count.sv
// Wrapping up/down position register with clear priority, plus registered
// change strobe and illegal-transition strobe.
// Assumes: clr is synchronous; wrap is plain modulo 2**WIDTH.
module quad_count
    import quad_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  step_t            step,
    output logic [WIDTH-1:0] count,
    output logic             evt,
    output logic             err
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_nxt;
    logic             evt_q;
    logic             err_q;

    // Next count: step first, clear overrides
    always_comb begin
        cnt_nxt = cnt_q;
        case (step)
            STEP_UP:   cnt_nxt = cnt_q + ONE;
            STEP_DOWN: cnt_nxt = cnt_q - ONE;
            default:   cnt_nxt = cnt_q;
        endcase
        if (clr) cnt_nxt = '0;
    end

    // Register count and both strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            evt_q <= (cnt_nxt != cnt_q);
            err_q <= (step == STEP_BAD);
        end
    end

    assign count = cnt_q;
    assign evt   = evt_q;
    assign err   = err_q;

endmodule

// File: rtl/quad_axis_counter.sv
// One encoder axis: synchronise A/B, decode each sampled transition, and
// drive a wrapping x4 up/down count with change and error strobes.
// Assumes: phase pulses last longer than SYNC_STAGES+1 clock periods.
module quad_axis_counter #(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             phase_a,
    input  logic             phase_b,
    output logic [WIDTH-1:0] count,
    output logic             count_evt,
    output logic             seq_err
);

    logic [1:0]      ab_sync;
    quad_pkg::step_t step;

    quad_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({phase_a, phase_b}),
        .dout  (ab_sync)
    );

    quad_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (ab_sync),
        .step  (step)
    );

    quad_count #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (step),
        .count (count),
        .evt   (count_evt),
        .err   (seq_err)
    );

endmodule

// File: rtl/quad_axis_checker.sv
// Property checker for quad_axis_counter, attached by bind.
// Assumes: reset is held low for at least one clock at start-up.
module quad_axis_checker #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic [WIDTH-1:0] count,
    input logic             count_evt,
    input logic             seq_err
);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_clr) |-> (count == '0));

    // R9
    evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_evt == (count != $past(count)));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !$past(cnt_clr)) |-> $stable(count));

    // R1
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_evt && !$past(cnt_clr)) |->
        ((count == $past(count) + WIDTH'(1)) || (count == $past(count) - WIDTH'(1))));

endmodule

bind quad_axis_counter quad_axis_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr   (cnt_clr),
    .count     (count),
    .count_evt (count_evt),
    .seq_err   (seq_err)
);

// File: tb/quad_axis_counter_test.sv
module quad_axis_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic [11:0] count;
    logic        count_evt;
    logic        seq_err;

    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;
    bit    model_ok = 1'b0;
    string tag = "R4";

    logic [1:0]  hq[$];
    logic [11:0] m_cnt = '0;
    logic        m_evt = 1'b0;
    logic        m_err = 1'b0;
    int          evt_seen = 0;
    int          err_seen = 0;

    always #5 clk = ~clk;

    quad_axis_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr   (cnt_clr),
        .phase_a   (phase_a),
        .phase_b   (phase_b),
        .count     (count),
        .count_evt (count_evt),
        .seq_err   (seq_err)
    );

    function automatic int gray_pos(logic [1:0] v);
        case (v)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] gray_at(int p);
        case (((p % 4) + 4) % 4)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // Behavioural reference: inputs reach the decision two edges after capture
    always @(posedge clk) begin
        if (!rst_n) begin
            hq = {};
            hq.push_back(2'b00); hq.push_back(2'b00); hq.push_back(2'b00);
            m_cnt = '0; m_evt = 1'b0; m_err = 1'b0;
            model_ok = 1'b1;
        end else begin
            logic [1:0]  cur;
            logic [1:0]  prv;
            logic [11:0] nxt;
            int          d;
            cur = hq[hq.size()-2];
            prv = hq[hq.size()-3];
            nxt = m_cnt;
            m_err = 1'b0;
            if ((cur ^ prv) == 2'b11) m_err = 1'b1;
            else if (cur != prv) begin
                d = (gray_pos(cur) - gray_pos(prv) + 4) % 4;
                nxt = (d == 1) ? m_cnt + 12'd1 : m_cnt - 12'd1;
            end
            if (cnt_clr) nxt = '0;
            m_evt = (nxt != m_cnt);
            m_cnt = nxt;
            hq.push_back({phase_a, phase_b});
            while (hq.size() > 4) void'(hq.pop_front());
        end
    end

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (model_ok && !done) begin
            tests++;
            if (count !== m_cnt || count_evt !== m_evt || seq_err !== m_err) begin
                fails++;
                $display("FAIL %s cycle compare: count=%h evt=%b err=%b expected count=%h evt=%b err=%b",
                         tag, count, count_evt, seq_err, m_cnt, m_evt, m_err);
            end
            if (count_evt === 1'b1) evt_seen++;
            if (seq_err === 1'b1)   err_seen++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Walk n Gray steps (positive up, negative down), holding each 3 cycles
    task automatic walk(int n);
        int p = gray_pos({phase_a, phase_b});
        int dir = (n >= 0) ? 1 : -1;
        int cnt = (n >= 0) ? n : -n;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            p = p + dir;
            {phase_a, phase_b} = gray_at(p);
            idle(2);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [11:0] old;
        idle(4);
        // R4 reset state
        check("R4 count", 32'(count), 32'h0);
        check("R4 evt", 32'(count_evt), 32'h0);
        check("R4 err", 32'(seq_err), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);

        tag = "R1";
        evt_seen = 0;
        walk(8);
        idle(5);
        check("R1 up count", 32'(count), 32'h8);
        check("R9 evt pulses", 32'(evt_seen), 32'd8);

        tag = "R3";
        old = count;
        @(negedge clk);
        {phase_a, phase_b} = gray_at(gray_pos({phase_a, phase_b}) + 1);
        @(negedge clk);
        @(negedge clk);
        check("R3 not yet", 32'(count), 32'(old));
        @(negedge clk);
        check("R3 count", 32'(count), 32'(old + 12'd1));
        check("R3 evt", 32'(count_evt), 32'h1);
        idle(3);

        tag = "R2";
        walk(-11);
        idle(5);
        check("R5 down wrap", 32'(count), 32'hFFE);
        tag = "R5";
        walk(3);
        idle(5);
        check("R5 up wrap", 32'(count), 32'h001);

        tag = "R10";
        evt_seen = 0;
        idle(20);
        check("R10 steady", 32'(count), 32'h001);
        check("R10 no evt", 32'(evt_seen), 32'd0);

        tag = "R7";
        @(negedge clk) phase_a = ~phase_a;
        idle(3);
        @(negedge clk) phase_a = ~phase_a;
        idle(3);
        @(negedge clk) phase_b = ~phase_b;
        idle(3);
        @(negedge clk) phase_b = ~phase_b;
        idle(6);
        check("R7 glitch net", 32'(count), 32'h001);

        tag = "R8";
        err_seen = 0;
        @(negedge clk) {phase_a, phase_b} = ~{phase_a, phase_b};
        idle(6);
        check("R8 no count", 32'(count), 32'h001);
        check("R8 err pulse", 32'(err_seen), 32'd1);

        tag = "R6";
        walk(4);
        idle(4);
        @(negedge clk) cnt_clr = 1'b1;
        walk(5);
        check("R6 held zero", 32'(count), 32'h0);
        @(negedge clk) cnt_clr = 1'b0;
        idle(6);
        check("R6 lost edges", 32'(count), 32'h0);
        walk(2);
        idle(5);
        check("R6 resume", 32'(count), 32'h2);
        // Clear sampled on the very edge the step would apply
        @(negedge clk);
        {phase_a, phase_b} = gray_at(gray_pos({phase_a, phase_b}) + 1);
        @(negedge clk);
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
        check("R6 clear wins", 32'(count), 32'h0);
        idle(5);
        check("R6 step not replayed", 32'(count), 32'h0);
        walk(1);
        idle(5);
        check("R6 next step", 32'(count), 32'h1);

        tag = "R4";
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R4 mid reset", 32'(count), 32'h0);
        {phase_a, phase_b} = 2'b00;
        idle(3);
        rst_n = 1'b1;
        idle(4);
        check("R4 after reset", 32'(count), 32'h0);

        summary();
    end

endmodule